// File: doc/BRIEF.md
# Neuron Chain Host Register Port

This block sits between a host bus and a chain of neurons. The host selects a register with a 4-bit address, sets a read/write select, lowers an active-low chip select and raises a data strobe. The port accepts the access on the rising strobe, turns it into a one-cycle command pulse for the neuron array, and holds its ready output low until the command has finished. For writes it captures the 16-bit bus value for the array. For reads it puts the result back on the shared bidirectional bus.

The time ready stays low depends on the command. A distance read waits long enough for the chain's search-and-sort. Other commands use a short fixed latency. Either can be stretched by a busy input from the array. The same address means different things in the two directions: address 3 reads the distance but writes the component index. A status register holds the save-and-restore mode flag, which gives direct access to individual neurons.

Top module: `nchain_host_port`

## Requirements
- R1: After reset `rdy` is 1, `cmd_op` is all zero, `sr_mode` is 0 and the port does not drive `data`.
- R2: An access is accepted on a clock edge where `strobe` is 1, `strobe` was 0 at the previous edge, `cs_n` is 0 and `rdy` is 1. From that edge on, `rdy` is 0, and `cmd_op` carries the command for exactly one cycle.
- R3: `cmd_op` is one-hot with this bit map: bit0 context (address 0x0), bit1 component write (0x1), bit2 last-component write (0x2), bit3 index write (0x3), bit4 distance read (0x3), bit5 category (0x4), bit6 active field (0x5), bit7 minimum field (0x6), bit8 maximum field (0x7), bit9 chain reset write (0xC), bit10 status (0xD). Reads of 0x1, 0x2 or 0xC, and any other address, give no bit.
- R4: Address 0x3 issues the distance-read bit when `rw`=1 and the index-write bit when `rw`=0.
- R5: With `core_busy` low, `rdy` stays low for DIST_CYC (18) cycles on a distance read and for BASE_CYC (3) cycles on any other access.
- R6: While `core_busy` is high, `rdy` stays low. It returns high at the first clock edge where the latency has run out and `core_busy` is low.
- R7: A read or a write of the category address raises the category bit, which tells the chain to move its pointer on to the next neuron.
- R8: A new strobe rising edge while `rdy` is low is ignored: it issues no command and does not change the length of the low period.
- R9: A strobe rising edge while `cs_n` is high is ignored: `rdy` stays high and no command is issued.
- R10: `data` is driven only while `cs_n`=0 and `rw`=1. After a read completes, `data` carries `core_rdata` as sampled at the completing edge.
- R11: A write to address 0xD copies data bit 4 into `sr_mode`. A read of 0xD returns `sr_mode` in bit 4, with all other bits zero.
- R12: `cmd_wdata` holds the bus value captured at the accepting edge of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| strobe | input | 1 | Data strobe, active high |
| rw | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 4 | Register address |
| data | inout | 16 | Shared data bus |
| rdy | output | 1 | Ready, low while a command runs |
| cmd_op | output | 11 | One-hot command pulse to the array |
| cmd_wdata | output | 16 | Write data captured at acceptance |
| sr_mode | output | 1 | Save-and-restore mode flag |
| core_busy | input | 1 | Array or sorter still working |
| core_rdata | input | 16 | Read result from the array |

## Verification
The assertions check on every cycle the rules that do not depend on a particular access:
- a falling `rdy` always follows an enabled strobe;
- command pulses are one-hot and appear only while `rdy` is low;
- a busy array keeps `rdy` low.

Only the bench scenarios can show the rest:
- the exact low-period lengths for distance reads and for other commands;
- the direction-dependent decode of address 3;
- the read data returned on the bus;
- that strobes arriving mid-command or without chip select are ignored.

// File: rtl/nchain_host_port.sv
module nchain_host_port #(
  parameter int DW       = 16,
  parameter int DIST_CYC = 18,
  parameter int BASE_CYC = 3,
  parameter int NOPS     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          strobe,
  input  logic          rw,
  input  logic [3:0]    reg_sel,
  inout  wire  [DW-1:0] data,
  output logic          rdy,
  output logic [NOPS-1:0] cmd_op,
  output logic [DW-1:0] cmd_wdata,
  output logic          sr_mode,
  input  logic          core_busy,
  input  logic [DW-1:0] core_rdata
);
  localparam int CW = $clog2(DIST_CYC + 1);
  localparam int OP_CTX = 0, OP_COMP = 1, OP_LCOMP = 2, OP_INDEX = 3, OP_DIST = 4,
                 OP_CAT = 5, OP_AIF = 6, OP_MINIF = 7, OP_MAXIF = 8, OP_RSTCH = 9, OP_STAT = 10;

  logic            stb_q, accept, rd_q, stat_q;
  logic [CW-1:0]   cnt;
  logic [NOPS-1:0] op_d;
  logic [DW-1:0]   rdata_q;

  assign accept = strobe && !stb_q && !cs_n && rdy;

  always_comb begin
    op_d = '0;
    case (reg_sel)
      4'h0: op_d[OP_CTX]   = 1'b1;
      4'h1: op_d[OP_COMP]  = !rw;
      4'h2: op_d[OP_LCOMP] = !rw;
      4'h3: if (rw) op_d[OP_DIST] = 1'b1; else op_d[OP_INDEX] = 1'b1;
      4'h4: op_d[OP_CAT]   = 1'b1;
      4'h5: op_d[OP_AIF]   = 1'b1;
      4'h6: op_d[OP_MINIF] = 1'b1;
      4'h7: op_d[OP_MAXIF] = 1'b1;
      4'hC: op_d[OP_RSTCH] = !rw;
      4'hD: op_d[OP_STAT]  = 1'b1;
      default: op_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q     <= 1'b0;
      rdy       <= 1'b1;
      cnt       <= '0;
      cmd_op    <= '0;
      cmd_wdata <= '0;
      sr_mode   <= 1'b0;
      rd_q      <= 1'b0;
      stat_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      stb_q  <= strobe;
      cmd_op <= accept ? op_d : '0;
      if (accept) begin
        rdy    <= 1'b0;
        cnt    <= CW'((op_d[OP_DIST] ? DIST_CYC : BASE_CYC) - 1);
        rd_q   <= rw;
        stat_q <= (reg_sel == 4'hD);
        if (!rw) begin
          cmd_wdata <= data;
          if (reg_sel == 4'hD) sr_mode <= data[4];
        end
      end else if (!rdy) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else if (!core_busy) begin
          rdy <= 1'b1;
          if (rd_q) rdata_q <= stat_q ? DW'({sr_mode, 4'b0000}) : core_rdata;
        end
      end
    end
  end

  assign data = (!cs_n && rw) ? rdata_q : 'z;

  // R2
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(strobe && !cs_n));
  // R3
  op_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cmd_op));
  // R2
  op_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (|cmd_op) |-> !rdy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && core_busy) |=> !rdy);
  // R6
  rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(!core_busy));
endmodule

// File: tb/test_nchain_host_port.sv
module test_nchain_host_port;
  logic clk = 0, rst_n = 0, cs_n = 1, strobe = 0, rw = 0, core_busy = 0;
  logic [3:0]  reg_sel = 0;
  logic [15:0] core_rdata = 0, tb_wdata = 0;
  logic        tb_oe = 0;
  wire  [15:0] data;
  logic        rdy, sr_mode;
  logic [10:0] cmd_op;
  logic [15:0] cmd_wdata;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign data = tb_oe ? tb_wdata : 'z;

  nchain_host_port i_nchain_host_port (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe(strobe),
    .rw(rw), .reg_sel(reg_sel), .data(data), .rdy(rdy), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .sr_mode(sr_mode), .core_busy(core_busy), .core_rdata(core_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one access; returns command seen after acceptance and the number of low cycles.
  task automatic access(input logic r, input logic [3:0] a, input logic [15:0] wd,
                        input int busy_cyc, input bit glitch,
                        output logic [10:0] op, output int low, output logic [15:0] rd);
    int extra_ops = 0;
    @(negedge clk);
    cs_n = 0; rw = r; reg_sel = a; tb_wdata = wd; tb_oe = !r;
    core_busy = (busy_cyc > 0);
    @(negedge clk); strobe = 1;
    @(negedge clk); op = cmd_op; low = 0;
    while (!rdy && low < 100) begin
      low++;
      if (low > 1 && cmd_op != 0) extra_ops++;
      if (low == busy_cyc) core_busy = 0;
      if (glitch && low == 3) strobe = 0;
      if (glitch && low == 4) strobe = 1;
      @(negedge clk);
    end
    rd = data;
    chk("R8 no extra command pulse", extra_ops, 0);
    strobe = 0; tb_oe = 0;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rdy", rdy, 1); chk("R1 cmd_op", cmd_op, 0); chk("R1 sr_mode", sr_mode, 0);
    tb_oe = 1; tb_wdata = 16'h5A5A; cs_n = 1; #1;
    chk("R1 bus free", data, 16'h5A5A); tb_oe = 0;
  endtask

  task automatic t_decode;
    logic [10:0] op; int low; logic [15:0] rd;
    logic [3:0] adr [12] = '{4'h0,4'h1,4'h2,4'h3,4'h4,4'h5,4'h6,4'h7,4'hC,4'hD,4'h9,4'h1};
    logic       dir [12] = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1};
    int         bitx[12] = '{0,1,2,3,5,6,7,8,9,10,-1,-1};
    for (int i = 0; i < 12; i++) begin
      access(dir[i], adr[i], 16'h1000 + 16'(i), 0, 0, op, low, rd);
      chk("R3 decode", op, bitx[i] < 0 ? 11'd0 : 11'(1) << bitx[i]);
      chk("R5 base length", low, 3);
    end
  endtask

  task automatic t_dist_index;
    logic [10:0] op; int low; logic [15:0] rd;
    core_rdata = 16'h0042;
    access(1, 4'h3, 0, 0, 0, op, low, rd);
    chk("R4 dist read op", op, 11'h010);
    chk("R5 dist length", low, 18);
    chk("R10 read data", rd, 16'h0042);
    access(0, 4'h3, 16'h0007, 0, 0, op, low, rd);
    chk("R4 index write op", op, 11'h008);
    chk("R12 wdata", cmd_wdata, 16'h0007);
    chk("R10 no drive on write", rd, 16'h0007);
  endtask

  task automatic t_cat;
    logic [10:0] op; int low; logic [15:0] rd;
    core_rdata = 16'h0123;
    access(1, 4'h4, 0, 0, 0, op, low, rd);
    chk("R7 cat read advance", op, 11'h020);
    chk("R10 cat read data", rd, 16'h0123);
    access(0, 4'h4, 16'h0009, 0, 0, op, low, rd);
    chk("R7 cat write advance", op, 11'h020);
  endtask

  task automatic t_busy;
    logic [10:0] op; int low; logic [15:0] rd;
    access(0, 4'h1, 16'h00AA, 10, 0, op, low, rd);
    chk("R6 busy extends", low, 10);
  endtask

  task automatic t_ignore;
    logic [10:0] op; int low; logic [15:0] rd;
    access(1, 4'h3, 0, 0, 1, op, low, rd);
    chk("R8 length unchanged", low, 18);
    @(negedge clk); cs_n = 1; rw = 0; reg_sel = 4'h1;
    @(negedge clk); strobe = 1;
    @(negedge clk); chk("R9 rdy stays high", rdy, 1); chk("R9 no command", cmd_op, 0);
    strobe = 0;
  endtask

  task automatic t_status;
    logic [10:0] op; int low; logic [15:0] rd;
    access(0, 4'hD, 16'h0010, 0, 0, op, low, rd);
    chk("R11 sr_mode set", sr_mode, 1);
    core_rdata = 16'hFFFF;
    access(1, 4'hD, 0, 0, 0, op, low, rd);
    chk("R11 status read", rd, 16'h0010);
    access(0, 4'hD, 16'h00EF, 0, 0, op, low, rd);
    chk("R11 sr_mode clear", sr_mode, 0);
  endtask

  initial begin
    fork
      begin
        #10 rst_n = 1;
        t_reset; t_decode; t_dist_index; t_cat; t_busy; t_ignore; t_status;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule